// File: doc/BRIEF.md
# Disk command queue sequencer

The sequencer sits between a host and a storage device that can only work on one operation at a time. The host pushes operation descriptors (sector address, transfer direction, notify mark) into an eight-slot queue. It may push many of them in a row and does not wait for earlier ones to finish. The sequencer offers the oldest unissued descriptor to the device over a valid/ready handshake. It then waits for the device's completion pulse. After that pulse it offers the next descriptor on its own, with no action from the host.

The host hears back only when it asked to. A completion event carrying the entry's tag (its queue slot number) is raised only for entries pushed with the notify mark set. All other entries retire silently. A host usually pushes a transaction as one implied seek followed by a handful of contiguous sectors, and marks only the last sector. It then gets one event per transaction instead of one per sector. A completion pulse that arrives while no operation is outstanding is dropped and recorded in a sticky error output.

Top module: `dcq_sequencer`

## Requirements
- R1: Each accepted push (`enq_valid` and `enq_ready` high at a clock edge) takes the slot shown on `enq_tag` in that cycle. Slots are handed out in rotation 0,1,...,7,0,... starting from 0 after reset, and that slot number is the entry's tag.
- R2: An entry holds its slot from its push until its completion. `enq_ready` is low exactly when all 8 slots are held. A push while `enq_ready` is low is dropped and never reaches the device.
- R3: When no operation is outstanding and an unissued entry exists, `dev_cmd_valid` is high with that entry's address, direction (`dev_cmd_write`, 1 = write) and tag. These stay unchanged until `dev_cmd_ready` is seen high.
- R4: Entries are offered to the device strictly in push order.
- R5: From the edge where the device accepts an operation until the edge where `dev_done` completes it, `dev_cmd_valid` stays low.
- R6: If an unissued entry exists when `dev_done` completes the outstanding operation, `dev_cmd_valid` is high in the very next cycle, with no host action.
- R7: When the completed entry was pushed with `enq_notify` = 1, `evt_valid` is high for exactly the one cycle after the completing edge, with `evt_tag` equal to that entry's tag.
- R8: Completing an entry pushed with `enq_notify` = 0 produces no `evt_valid` pulse.
- R9: A `dev_done` pulse while nothing is outstanding changes no queue state. It sets `err_spurious`, which stays high until reset.
- R10: While `rst_n` is low, the queue empties and nothing is outstanding. Outputs then read `enq_ready` = 1, `enq_tag` = 0, `dev_cmd_valid` = 0, `evt_valid` = 0 and `err_spurious` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| enq_valid | input | 1 | Host offers a descriptor |
| enq_ready | output | 1 | A free slot exists |
| enq_lba | input | LBA_W | Sector address of the offered descriptor |
| enq_write | input | 1 | Direction, 1 = write |
| enq_notify | input | 1 | Request a completion event |
| enq_tag | output | TAG_W | Slot the offered descriptor would take |
| dev_cmd_valid | output | 1 | Operation offered to device |
| dev_cmd_ready | input | 1 | Device accepts the offered operation |
| dev_cmd_lba | output | LBA_W | Sector address of offered operation |
| dev_cmd_write | output | 1 | Direction of offered operation |
| dev_cmd_tag | output | TAG_W | Tag of offered operation |
| dev_done | input | 1 | Device completion pulse |
| evt_valid | output | 1 | Completion event for a marked entry |
| evt_tag | output | TAG_W | Tag of the completed marked entry |
| err_spurious | output | 1 | Sticky: completion seen with nothing outstanding |

## Verification
Some properties are checked on every cycle by the assertions. These are the single-outstanding rule, the stability of an offered operation while it waits, and the issue of the next operation right after a completion. They also cover tag order at acceptance, event tag against the accepted operation, full/ready against a separately counted occupancy, and the setting and holding of the error flag. Other behaviour only shows up in the bench's scenarios. That includes dropped pushes when full, whose effect appears only as a missing operation later in the stream, and silent retirement of unmarked entries inside a seek-plus-sectors transaction. It also includes the address and direction values carried end to end, and a stray completion leaving the queue contents intact.

// File: rtl/dcq_pkg.sv
package dcq_pkg;
  parameter int unsigned DCQ_LBA_W = 32;

  typedef struct packed {
    logic [DCQ_LBA_W-1:0] lba;
    logic                 write;
    logic                 notify;
  } dcq_desc_t;
endpackage

// File: rtl/dcq_queue.sv
// Slot storage plus three pointers: push, next-to-issue, oldest-held.
module dcq_queue
  import dcq_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  dcq_desc_t                  push_d,
  input  logic                       issue,
  input  logic                       retire,
  output logic                       full,
  output logic                       pending,
  output logic [$clog2(DEPTH)-1:0]   wr_tag,
  output dcq_desc_t                  iss_d,
  output logic [$clog2(DEPTH)-1:0]   iss_tag,
  output logic                       ret_notify,
  output logic [$clog2(DEPTH)-1:0]   ret_tag
);
  localparam int unsigned TAG_W = $clog2(DEPTH);
  localparam int unsigned PTR_W = TAG_W + 1;

  logic [PTR_W-1:0] wr_q, wr_d, iss_q, iss_d_ptr, ret_q, ret_d;
  dcq_desc_t        slots [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    dcq_desc_t slot_q;
    logic      slot_en;
    assign slot_en = push && (wr_q[TAG_W-1:0] == TAG_W'(g));
    always_ff @(posedge clk) begin
      if (slot_en) slot_q <= push_d;
    end
    assign slots[g] = slot_q;
  end

  always_comb begin
    wr_d      = wr_q;
    iss_d_ptr = iss_q;
    ret_d     = ret_q;
    if (push)   wr_d      = wr_q + PTR_W'(1);
    if (issue)  iss_d_ptr = iss_q + PTR_W'(1);
    if (retire) ret_d     = ret_q + PTR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      iss_q <= '0;
      ret_q <= '0;
    end else begin
      wr_q  <= wr_d;
      iss_q <= iss_d_ptr;
      ret_q <= ret_d;
    end
  end

  assign full       = (wr_q[TAG_W-1:0] == ret_q[TAG_W-1:0]) && (wr_q[TAG_W] != ret_q[TAG_W]);
  assign pending    = (iss_q != wr_q);
  assign wr_tag     = wr_q[TAG_W-1:0];
  assign iss_tag    = iss_q[TAG_W-1:0];
  assign iss_d      = slots[iss_q[TAG_W-1:0]];
  assign ret_tag    = ret_q[TAG_W-1:0];
  assign ret_notify = slots[ret_q[TAG_W-1:0]].notify;
endmodule

// File: rtl/dcq_issue.sv
// Device handshake: one outstanding operation, completion and stray-pulse detection.
module dcq_issue (
  input  logic clk,
  input  logic rst_n,
  input  logic pending,
  input  logic dev_ready,
  input  logic dev_done,
  output logic cmd_valid,
  output logic issue,
  output logic retire,
  output logic err
);
  logic busy_q, busy_d, err_q, err_d;

  assign cmd_valid = !busy_q && pending;
  assign issue     = cmd_valid && dev_ready;
  assign retire    = dev_done && busy_q;

  always_comb begin
    busy_d = busy_q;
    if (issue)       busy_d = 1'b1;
    else if (retire) busy_d = 1'b0;
    err_d = err_q | (dev_done && !busy_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      err_q  <= err_d;
    end
  end

  assign err = err_q;
endmodule

// File: rtl/dcq_event.sv
// One-cycle completion event for entries that carried the notify mark.
module dcq_event #(
  parameter int unsigned TAG_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             retire,
  input  logic             notify,
  input  logic [TAG_W-1:0] tag,
  output logic             evt_valid,
  output logic [TAG_W-1:0] evt_tag
);
  logic             v_q, v_d;
  logic [TAG_W-1:0] t_q, t_d;

  always_comb begin
    v_d = retire && notify;
    t_d = t_q;
    if (retire) t_d = tag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= 1'b0;
      t_q <= '0;
    end else begin
      v_q <= v_d;
      t_q <= t_d;
    end
  end

  assign evt_valid = v_q;
  assign evt_tag   = t_q;
endmodule

// File: rtl/dcq_sequencer.sv
module dcq_sequencer
  import dcq_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned LBA_W = DCQ_LBA_W,
  localparam int unsigned TAG_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enq_valid,
  output logic             enq_ready,
  input  logic [LBA_W-1:0] enq_lba,
  input  logic             enq_write,
  input  logic             enq_notify,
  output logic [TAG_W-1:0] enq_tag,
  output logic             dev_cmd_valid,
  input  logic             dev_cmd_ready,
  output logic [LBA_W-1:0] dev_cmd_lba,
  output logic             dev_cmd_write,
  output logic [TAG_W-1:0] dev_cmd_tag,
  input  logic             dev_done,
  output logic             evt_valid,
  output logic [TAG_W-1:0] evt_tag,
  output logic             err_spurious
);
  logic       full, pending, push, issue, retire, ret_notify;
  logic [TAG_W-1:0] ret_tag;
  dcq_desc_t  push_d, iss_d;

  assign push_d.lba    = DCQ_LBA_W'(enq_lba);
  assign push_d.write  = enq_write;
  assign push_d.notify = enq_notify;
  assign enq_ready     = !full;
  assign push          = enq_valid && !full;

  dcq_queue #(.DEPTH(DEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n), .push(push), .push_d(push_d),
    .issue(issue), .retire(retire), .full(full), .pending(pending),
    .wr_tag(enq_tag), .iss_d(iss_d), .iss_tag(dev_cmd_tag),
    .ret_notify(ret_notify), .ret_tag(ret_tag)
  );

  dcq_issue u_issue (
    .clk(clk), .rst_n(rst_n), .pending(pending), .dev_ready(dev_cmd_ready),
    .dev_done(dev_done), .cmd_valid(dev_cmd_valid), .issue(issue),
    .retire(retire), .err(err_spurious)
  );

  dcq_event #(.TAG_W(TAG_W)) u_event (
    .clk(clk), .rst_n(rst_n), .retire(retire), .notify(ret_notify),
    .tag(ret_tag), .evt_valid(evt_valid), .evt_tag(evt_tag)
  );

  assign dev_cmd_lba   = LBA_W'(iss_d.lba);
  assign dev_cmd_write = iss_d.write;
endmodule

// File: rtl/dcq_sequencer_chk.sv
module dcq_sequencer_chk #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned LBA_W = 32,
  localparam int unsigned TAG_W = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enq_valid,
  input logic             enq_ready,
  input logic             dev_cmd_valid,
  input logic             dev_cmd_ready,
  input logic [LBA_W-1:0] dev_cmd_lba,
  input logic             dev_cmd_write,
  input logic [TAG_W-1:0] dev_cmd_tag,
  input logic             dev_done,
  input logic             evt_valid,
  input logic [TAG_W-1:0] evt_tag,
  input logic             err_spurious
);
  logic [TAG_W:0]   occ;
  logic             out;
  logic [TAG_W-1:0] out_tag, nxt_tag;
  logic             acc, fin;

  assign acc = dev_cmd_valid && dev_cmd_ready;
  assign fin = dev_done && out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ     <= '0;
      out     <= 1'b0;
      out_tag <= '0;
      nxt_tag <= '0;
    end else begin
      occ <= occ + (TAG_W+1)'(enq_valid && enq_ready) - (TAG_W+1)'(fin);
      if (acc) begin
        out     <= 1'b1;
        out_tag <= dev_cmd_tag;
        nxt_tag <= nxt_tag + TAG_W'(1);
      end else if (fin) begin
        out <= 1'b0;
      end
    end
  end

  AST_FULL_READY: assert property (@(posedge clk) disable iff (!rst_n)
    enq_ready == (occ != (TAG_W+1)'(DEPTH))); // R2
  AST_HOLD_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    dev_cmd_valid && !dev_cmd_ready |=> dev_cmd_valid && $stable(dev_cmd_tag)
      && $stable(dev_cmd_lba) && $stable(dev_cmd_write)); // R3
  AST_TAG_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    acc |-> dev_cmd_tag == nxt_tag); // R4
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    out |-> !dev_cmd_valid); // R5
  AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    fin && occ > (TAG_W+1)'(1) |=> dev_cmd_valid); // R6
  AST_EVT_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !evt_valid || evt_tag == $past(out_tag)); // R7
  AST_EVT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !fin |=> !evt_valid); // R8
  AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    dev_done && !out |=> err_spurious); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_spurious |=> err_spurious); // R9
endmodule

bind dcq_sequencer dcq_sequencer_chk #(.DEPTH(DEPTH), .LBA_W(LBA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_ready(enq_ready),
  .dev_cmd_valid(dev_cmd_valid), .dev_cmd_ready(dev_cmd_ready),
  .dev_cmd_lba(dev_cmd_lba), .dev_cmd_write(dev_cmd_write),
  .dev_cmd_tag(dev_cmd_tag), .dev_done(dev_done), .evt_valid(evt_valid),
  .evt_tag(evt_tag), .err_spurious(err_spurious)
);

// File: tb/dcq_sequencer_test.sv
`timescale 1ns/1ps
module dcq_sequencer_test;
  localparam int DEPTH = 8;
  localparam int LBA_W = 32;
  localparam int TAG_W = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic enq_valid, enq_write, enq_notify, dev_cmd_ready, dev_done;
  logic [LBA_W-1:0] enq_lba;
  logic enq_ready, dev_cmd_valid, dev_cmd_write, evt_valid, err_spurious;
  logic [TAG_W-1:0] enq_tag, dev_cmd_tag, evt_tag;
  logic [LBA_W-1:0] dev_cmd_lba;

  always #10 clk = ~clk;

  dcq_sequencer #(.DEPTH(DEPTH), .LBA_W(LBA_W)) uut (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_ready(enq_ready),
    .enq_lba(enq_lba), .enq_write(enq_write), .enq_notify(enq_notify),
    .enq_tag(enq_tag), .dev_cmd_valid(dev_cmd_valid), .dev_cmd_ready(dev_cmd_ready),
    .dev_cmd_lba(dev_cmd_lba), .dev_cmd_write(dev_cmd_write), .dev_cmd_tag(dev_cmd_tag),
    .dev_done(dev_done), .evt_valid(evt_valid), .evt_tag(evt_tag),
    .err_spurious(err_spurious)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // reference model state
  logic [LBA_W-1:0] m_lba [DEPTH];
  bit  m_wrb [DEPTH];
  bit  m_nt  [DEPTH];
  int  m_wr, m_iss, m_ret;
  bit  m_busy, m_evt, m_err;
  int  m_btag, m_etag;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit exp_ready(); return (m_wr - m_ret) < DEPTH; endfunction
  function automatic bit exp_cmd();   return !m_busy && (m_iss < m_wr); endfunction

  task automatic model_reset();
    m_wr = 0; m_iss = 0; m_ret = 0;
    m_busy = 0; m_evt = 0; m_err = 0; m_btag = 0; m_etag = 0;
  endtask

  task automatic check_all();
    int s;
    s = m_iss % DEPTH;
    chk(enq_ready == exp_ready(), "R2", "enq_ready", enq_ready, exp_ready());
    chk(enq_tag == TAG_W'(m_wr % DEPTH), "R1", "enq_tag", enq_tag, m_wr % DEPTH);
    chk(dev_cmd_valid == exp_cmd(), m_busy ? "R5" : "R6", "dev_cmd_valid",
        dev_cmd_valid, exp_cmd());
    if (exp_cmd()) begin
      chk(dev_cmd_tag == TAG_W'(s), "R4", "dev_cmd_tag", dev_cmd_tag, s);
      chk(dev_cmd_lba == m_lba[s], "R3", "dev_cmd_lba", dev_cmd_lba, m_lba[s]);
      chk(dev_cmd_write == m_wrb[s], "R3", "dev_cmd_write", dev_cmd_write, m_wrb[s]);
    end
    chk(evt_valid == m_evt, m_evt ? "R7" : "R8", "evt_valid", evt_valid, m_evt);
    if (m_evt)
      chk(evt_tag == TAG_W'(m_etag), "R7", "evt_tag", evt_tag, m_etag);
    chk(err_spurious == m_err, "R9", "err_spurious", err_spurious, m_err);
  endtask

  // one cycle: check at negedge, drive, advance model, wait for next negedge
  task automatic cycle(input bit ev, input logic [LBA_W-1:0] lba, input bit wr,
                       input bit nt, input bit rdy, input bit done);
    bit push, acc, ret;
    check_all();
    enq_valid = ev; enq_lba = lba; enq_write = wr; enq_notify = nt;
    dev_cmd_ready = rdy; dev_done = done;
    push = ev && exp_ready();
    acc  = exp_cmd() && rdy;
    ret  = done && m_busy;
    m_evt = ret && m_nt[m_btag];
    if (ret) m_etag = m_btag;
    if (done && !m_busy) m_err = 1;
    if (push) begin
      m_lba[m_wr % DEPTH] = lba; m_wrb[m_wr % DEPTH] = wr; m_nt[m_wr % DEPTH] = nt;
      m_wr++;
    end
    if (acc) begin m_busy = 1; m_btag = m_iss % DEPTH; m_iss++; end
    else if (ret) begin m_busy = 0; m_ret++; end
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; enq_valid = 0; enq_lba = '0; enq_write = 0; enq_notify = 0;
    dev_cmd_ready = 0; dev_done = 0;
    model_reset();
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(enq_ready == 1'b1, "R10", "enq_ready", enq_ready, 1);
    chk(enq_tag == '0, "R10", "enq_tag", enq_tag, 0);
    chk(dev_cmd_valid == 1'b0, "R10", "dev_cmd_valid", dev_cmd_valid, 0);
    chk(evt_valid == 1'b0, "R10", "evt_valid", evt_valid, 0);
    chk(err_spurious == 1'b0, "R10", "err_spurious", err_spurious, 0);
    rst_n = 1;
    @(negedge clk);

    // R2: fill with device stalled, then push past full
    for (int i = 0; i < 11; i++)
      cycle(1, 32'h1000 + i, i[0], (i == 3), 0, 0);
    chk(enq_ready == 1'b0, "R2", "enq_ready when full", enq_ready, 0);
    // R9 spurious done at idle (nothing accepted yet) leaves queue intact
    cycle(0, 0, 0, 0, 0, 1);
    // R4 R6: drain with immediate completions; dropped pushes never appear
    for (int i = 0; i < 30; i++)
      cycle(0, 0, 0, 0, 1, m_busy);

    // R7 R8: seek plus six sectors, notify only on the last
    for (int i = 0; i < 7; i++)
      cycle(1, 32'h5000 + i, 0, (i == 6), 0, 0);
    for (int i = 0; i < 25; i++)
      cycle(0, 0, 0, 0, 1, m_busy);

    // reset again to clear the sticky flag, then random traffic
    rst_n = 0; model_reset();
    @(negedge clk);
    chk(err_spurious == 1'b0, "R10", "err after reset", err_spurious, 0);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < 6000; i++) begin
      bit ev, rdy, dn;
      ev  = ($urandom % 3) != 0;
      rdy = ($urandom % 4) != 0;
      dn  = m_busy ? (($urandom % 3) == 0) : (($urandom % 500) == 0);
      cycle(ev, $urandom, $urandom % 2, ($urandom % 4) == 0, rdy, dn);
    end
    for (int i = 0; i < 40; i++)
      cycle(0, 0, 0, 0, 1, m_busy);
    check_all();

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule